// File: doc/BRIEF.md
# LPC Peripheral Host-Interface Control/Status Register

This block is an 8-bit register that a local CPU reads and writes to observe and steer the peripheral side of an LPC host interface. The upper three bits are read-only status flags. Event strobes from the LPC cycle decoder and from the serial-IRQ engine raise and lower them. They report a transfer aimed at this interface, a request to restart the LPC clock, and an active serial-IRQ frame.

The middle two bits are sticky software controls: a software reset and a software shutdown. Each is guarded against stray writes. A write of 1 takes effect only when the previous access to that bit was a read that returned 0. A write of 0 always clears the bit. The shutdown bit also follows an asynchronous power-down input. A mode input picks which edge of that input means "enter shutdown"; the other edge means "leave shutdown".

The low three bits are the data values of three open-drain sideband pins: wake, system-management interrupt and system-control interrupt. An enable held in another register qualifies each pin. When the enable is low, the pin is handed back to its alternate function. When the enable is high, a 0 pulls the pin low and a 1 floats it.

Top module: `lpc_csr_top`

## Requirements
- R1: After reset every register bit reads 0, `sw_rst_o` is 0, and `sb_own_o` and `sb_low_o` are 0 when all enables are 0.
- R2: Bits 7, 6 and 5 of `cpu_rdata` cannot be changed by a CPU write.
- R3: Bit 7 (transfer busy) sets one cycle after `cyc_match`. It clears one cycle after `cyc_done`, `cyc_abort`, `lpc_hw_rst`, an active software reset (bit 4 = 1) or an active shutdown (bit 3 = 1 or a hardware shutdown edge). A clear wins over a set in the same cycle.
- R4: Bit 5 (serial-IRQ busy) sets one cycle after `frm_start`. It clears one cycle after `frm_end`, any LPC reset or any shutdown. A clear wins over a set in the same cycle.
- R5: Bit 6 (clock restart request) sets one cycle after `sirq_cont`, `quiet_need_clk`, `lpc_hw_rst` or while bit 4 = 1. It clears one cycle after `quiet_idle`, and that clear wins over a set in the same cycle.
- R6: Bit 4 (software reset) sets on a write with bit 4 = 1 only when the previous access to the register was a read that returned bit 4 = 0. Every write consumes that permission. A write with bit 4 = 0 clears the bit. `sw_rst_o` equals bit 4.
- R7: Bit 3 (software shutdown) uses the same read-0-then-write-1 rule as R6. It clears one cycle after a write with bit 3 = 0, after `lpc_hw_rst`, or while bit 4 = 1.
- R8: When `pd_fall_sel` = 1, a falling edge on `pd_pin` sets bit 3 and a rising edge clears it; when `pd_fall_sel` = 0, the edges swap roles. Counting from the first clock edge after `pd_pin` changes, bit 3 changes on the third clock edge.
- R9: Bits 2, 1 and 0 are plain read/write data for the wake, SMI and SCI pins. For each pin i, `sb_own_o[i]` = `sb_en[i]` and `sb_low_o[i]` = `sb_en[i]` AND NOT bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | CPU read strobe (one cycle) |
| cpu_wr | input | 1 | CPU write strobe (one cycle) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register contents |
| lpc_hw_rst | input | 1 | LPC hardware reset from the bus |
| cyc_match | input | 1 | Decoder: cycle type and address match |
| cyc_done | input | 1 | Decoder: matching cycle completed |
| cyc_abort | input | 1 | Decoder: matching cycle aborted |
| frm_start | input | 1 | Serial-IRQ frame begins |
| frm_end | input | 1 | Serial-IRQ frame ends |
| sirq_cont | input | 1 | Serial IRQ running in continuous mode |
| quiet_need_clk | input | 1 | Quiet mode needs an interrupt sent while clock stopped |
| quiet_idle | input | 1 | Quiet mode has nothing further to send |
| pd_pin | input | 1 | Asynchronous power-down input |
| pd_fall_sel | input | 1 | 1: falling edge enters shutdown; 0: rising edge does |
| sb_en | input | 3 | Sideband enables [2]=wake [1]=SMI [0]=SCI |
| sw_rst_o | output | 1 | Software-reset request to the LPC logic |
| sb_own_o | output | 3 | Pin owned by sideband function (else alternate function) |
| sb_low_o | output | 3 | Drive pin low (else high impedance) |

## Verification
The bench writes 1 to the guarded bits with no read before it, and after a read whose permission a write has already used up. A design that forgot to consume the permission, or that never required it, would set software reset or shutdown on a stray write. Same-cycle set and clear strobes on each status flag catch a design that gives the set priority, which would leave the flag stuck high. The power-down edge is tested in both modes, with samples one cycle before and on the expected cycle. A design with the mode inverted, a missing synchronizer stage or a missing release path would show the wrong bit 3. Status events arriving while shutdown or software reset is active, and enabled sideband pins with mixed data, expose flags that ignore the clearing conditions and drivers that ignore the enable.

// File: rtl/lpc_csr_pkg.sv
`timescale 1ns/1ps
package lpc_csr_pkg;
    localparam int REG_W  = 8;
    localparam int N_SB   = 3;
    localparam int B_XBSY = 7;
    localparam int B_CREQ = 6;
    localparam int B_SBSY = 5;
    localparam int B_SRST = 4;
    localparam int B_SSDN = 3;

    typedef struct packed {
        logic xbsy;
        logic creq;
        logic sbsy;
    } stat_t;
endpackage

// File: rtl/lpc_csr_pd_edge.sv
`timescale 1ns/1ps
module lpc_csr_pd_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_pin,
    input  logic fall_is_sdn,
    output logic sdn_pulse,
    output logic rel_pulse
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } pd_st_t;

    pd_st_t st_d, st_q;
    logic   rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pd_pin};
        st_d.prev = st_q.sync[MSB];
        rise      = st_q.sync[MSB] & ~st_q.prev;
        fall      = ~st_q.sync[MSB] & st_q.prev;
        sdn_pulse = fall_is_sdn ? fall : rise;
        rel_pulse = fall_is_sdn ? rise : fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lpc_csr_status.sv
`timescale 1ns/1ps
module lpc_csr_status
    import lpc_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lpc_rst,
    input  logic  sdn_any,
    input  logic  cyc_match,
    input  logic  cyc_done,
    input  logic  cyc_abort,
    input  logic  frm_start,
    input  logic  frm_end,
    input  logic  sirq_cont,
    input  logic  quiet_need_clk,
    input  logic  quiet_idle,
    output stat_t stat_o
);
    stat_t st_d, st_q;
    logic  x_set, x_clr, s_set, s_clr, c_set, c_clr;

    always_comb begin
        x_set = cyc_match;
        x_clr = cyc_done | cyc_abort | lpc_rst | sdn_any;
        s_set = frm_start;
        s_clr = frm_end | lpc_rst | sdn_any;
        c_set = sirq_cont | quiet_need_clk | lpc_rst;
        c_clr = quiet_idle;

        st_d = st_q;
        if (x_clr)      st_d.xbsy = 1'b0;
        else if (x_set) st_d.xbsy = 1'b1;
        if (s_clr)      st_d.sbsy = 1'b0;
        else if (s_set) st_d.sbsy = 1'b1;
        if (c_clr)      st_d.creq = 1'b0;
        else if (c_set) st_d.creq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q;
endmodule

// File: rtl/lpc_csr_ctrl.sv
`timescale 1ns/1ps
module lpc_csr_ctrl
    import lpc_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic            wr,
    input  logic [4:0]      wdata,
    input  logic            hw_rst,
    input  logic            sdn_pulse,
    input  logic            rel_pulse,
    output logic            srst_o,
    output logic            ssdn_o,
    output logic [N_SB-1:0] sb_o
);
    typedef struct packed {
        logic            srst;
        logic            ssdn;
        logic            arm_rst;
        logic            arm_sdn;
        logic [N_SB-1:0] sb;
    } ctl_t;

    ctl_t ct_d, ct_q;
    logic d_set, d_clr;

    always_comb begin
        ct_d = ct_q;

        // permission bookkeeping: reads arm, every write disarms
        if (wr) begin
            ct_d.arm_rst = 1'b0;
            ct_d.arm_sdn = 1'b0;
        end else if (rd) begin
            ct_d.arm_rst = ~ct_q.srst;
            ct_d.arm_sdn = ~ct_q.ssdn;
        end

        // software reset bit
        if (wr) begin
            if (!wdata[B_SRST])  ct_d.srst = 1'b0;
            else if (ct_q.arm_rst) ct_d.srst = 1'b1;
        end

        // software shutdown bit, clear beats set
        d_set = (wr & wdata[B_SSDN] & ct_q.arm_sdn) | sdn_pulse;
        d_clr = (wr & ~wdata[B_SSDN]) | hw_rst | ct_q.srst | rel_pulse;
        if (d_clr)      ct_d.ssdn = 1'b0;
        else if (d_set) ct_d.ssdn = 1'b1;

        if (wr) ct_d.sb = wdata[N_SB-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign srst_o = ct_q.srst;
    assign ssdn_o = ct_q.ssdn;
    assign sb_o   = ct_q.sb;
endmodule

// File: rtl/lpc_csr_top.sv
`timescale 1ns/1ps
module lpc_csr_top
    import lpc_csr_pkg::*;
#(
    parameter int PD_SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             lpc_hw_rst,
    input  logic             cyc_match,
    input  logic             cyc_done,
    input  logic             cyc_abort,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic             sirq_cont,
    input  logic             quiet_need_clk,
    input  logic             quiet_idle,
    input  logic             pd_pin,
    input  logic             pd_fall_sel,
    input  logic [N_SB-1:0]  sb_en,
    output logic             sw_rst_o,
    output logic [N_SB-1:0]  sb_own_o,
    output logic [N_SB-1:0]  sb_low_o
);
    logic            w_sdn_pulse, w_rel_pulse;
    logic            w_srst, w_ssdn;
    logic [N_SB-1:0] w_sb;
    stat_t           w_stat;
    logic            lpc_rst, sdn_any;

    assign lpc_rst = lpc_hw_rst | w_srst;
    assign sdn_any = w_sdn_pulse | w_ssdn;

    lpc_csr_pd_edge #(.SYNC_STAGES(PD_SYNC)) u_pd (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_pin      (pd_pin),
        .fall_is_sdn (pd_fall_sel),
        .sdn_pulse   (w_sdn_pulse),
        .rel_pulse   (w_rel_pulse)
    );

    lpc_csr_status u_stat (
        .clk            (clk),
        .rst_n          (rst_n),
        .lpc_rst        (lpc_rst),
        .sdn_any        (sdn_any),
        .cyc_match      (cyc_match),
        .cyc_done       (cyc_done),
        .cyc_abort      (cyc_abort),
        .frm_start      (frm_start),
        .frm_end        (frm_end),
        .sirq_cont      (sirq_cont),
        .quiet_need_clk (quiet_need_clk),
        .quiet_idle     (quiet_idle),
        .stat_o         (w_stat)
    );

    lpc_csr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .wdata     (cpu_wdata[4:0]),
        .hw_rst    (lpc_hw_rst),
        .sdn_pulse (w_sdn_pulse),
        .rel_pulse (w_rel_pulse),
        .srst_o    (w_srst),
        .ssdn_o    (w_ssdn),
        .sb_o      (w_sb)
    );

    always_comb begin
        cpu_rdata         = '0;
        cpu_rdata[B_XBSY] = w_stat.xbsy;
        cpu_rdata[B_CREQ] = w_stat.creq;
        cpu_rdata[B_SBSY] = w_stat.sbsy;
        cpu_rdata[B_SRST] = w_srst;
        cpu_rdata[B_SSDN] = w_ssdn;
        cpu_rdata[N_SB-1:0] = w_sb;
    end

    assign sw_rst_o = w_srst;

    for (genvar i = 0; i < N_SB; i++) begin : g_sb
        assign sb_own_o[i] = sb_en[i];
        assign sb_low_o[i] = sb_en[i] & ~w_sb[i];
    end
endmodule

// File: rtl/lpc_csr_chk.sv
`timescale 1ns/1ps
module lpc_csr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_wr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic       cyc_done,
    input logic       cyc_abort,
    input logic       frm_end,
    input logic       quiet_idle,
    input logic       sdn_pulse,
    input logic [2:0] sb_en,
    input logic [2:0] sb_low_o
);
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done || cyc_abort) |=> !cpu_rdata[7]);

    a_r4_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |=> !cpu_rdata[5]);

    a_r5_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_idle |=> !cpu_rdata[6]);

    a_r6_rst_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rdata[4]) |-> $past(cpu_wr && cpu_wdata[4]));

    a_r7_sdn_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rdata[3]) |-> ($past(cpu_wr && cpu_wdata[3]) || $past(sdn_pulse)));

    a_r9_low_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_low_o & ~sb_en) == 3'b000);
endmodule

bind lpc_csr_top lpc_csr_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .cyc_done   (cyc_done),
    .cyc_abort  (cyc_abort),
    .frm_end    (frm_end),
    .quiet_idle (quiet_idle),
    .sdn_pulse  (w_sdn_pulse),
    .sb_en      (sb_en),
    .sb_low_o   (sb_low_o)
);

// File: tb/test_lpc_csr_top.sv
`timescale 1ns/1ps
module test_lpc_csr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       lpc_hw_rst = 1'b0, cyc_match = 1'b0, cyc_done = 1'b0, cyc_abort = 1'b0;
    logic       frm_start = 1'b0, frm_end = 1'b0, sirq_cont = 1'b0;
    logic       quiet_need_clk = 1'b0, quiet_idle = 1'b0;
    logic       pd_pin = 1'b0, pd_fall_sel = 1'b0;
    logic [2:0] sb_en = 3'b000;
    logic       sw_rst_o;
    logic [2:0] sb_own_o, sb_low_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lpc_csr_top i_lpc_csr_top (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .lpc_hw_rst(lpc_hw_rst),
        .cyc_match(cyc_match), .cyc_done(cyc_done), .cyc_abort(cyc_abort),
        .frm_start(frm_start), .frm_end(frm_end), .sirq_cont(sirq_cont),
        .quiet_need_clk(quiet_need_clk), .quiet_idle(quiet_idle),
        .pd_pin(pd_pin), .pd_fall_sel(pd_fall_sel), .sb_en(sb_en),
        .sw_rst_o(sw_rst_o), .sb_own_o(sb_own_o), .sb_low_o(sb_low_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cpu_read();
        cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] v);
        cpu_wr = 1'b1; cpu_wdata = v; step(); cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", cpu_rdata, 8'h00);
        check("R1 sw_rst_o", {7'b0, sw_rst_o}, 8'h00);
        check("R1 sb_own", {5'b0, sb_own_o}, 8'h00);
        check("R1 sb_low", {5'b0, sb_low_o}, 8'h00);
    endtask

    task automatic t_ro();
        cpu_write(8'hE0);
        check("R2 ro bits", {5'b0, cpu_rdata[7:5]}, 8'h00);
    endtask

    task automatic t_busy();
        cyc_match = 1; step(); cyc_match = 0;
        check("R3 match sets", {7'b0, cpu_rdata[7]}, 8'h01);
        cyc_done = 1; step(); cyc_done = 0;
        check("R3 done clears", {7'b0, cpu_rdata[7]}, 8'h00);
        cyc_match = 1; step(); cyc_match = 0;
        cyc_abort = 1; step(); cyc_abort = 0;
        check("R3 abort clears", {7'b0, cpu_rdata[7]}, 8'h00);
        cyc_match = 1; cyc_done = 1; step(); cyc_match = 0; cyc_done = 0;
        check("R3 clear wins", {7'b0, cpu_rdata[7]}, 8'h00);
    endtask

    task automatic t_sirq();
        frm_start = 1; step(); frm_start = 0;
        check("R4 start sets", {7'b0, cpu_rdata[5]}, 8'h01);
        frm_end = 1; step(); frm_end = 0;
        check("R4 end clears", {7'b0, cpu_rdata[5]}, 8'h00);
        frm_start = 1; frm_end = 1; step(); frm_start = 0; frm_end = 0;
        check("R4 clear wins", {7'b0, cpu_rdata[5]}, 8'h00);
    endtask

    task automatic t_clk();
        sirq_cont = 1; step(); sirq_cont = 0;
        check("R5 cont sets", {7'b0, cpu_rdata[6]}, 8'h01);
        quiet_idle = 1; step(); quiet_idle = 0;
        check("R5 idle clears", {7'b0, cpu_rdata[6]}, 8'h00);
        quiet_need_clk = 1; step(); quiet_need_clk = 0;
        check("R5 quiet need sets", {7'b0, cpu_rdata[6]}, 8'h01);
        quiet_idle = 1; sirq_cont = 1; step(); quiet_idle = 0; sirq_cont = 0;
        check("R5 clear wins", {7'b0, cpu_rdata[6]}, 8'h00);
        cyc_match = 1; step(); cyc_match = 0;
        lpc_hw_rst = 1; step(); lpc_hw_rst = 0;
        check("R5 hw reset sets", {7'b0, cpu_rdata[6]}, 8'h01);
        check("R3 hw reset clears", {7'b0, cpu_rdata[7]}, 8'h00);
    endtask

    task automatic t_rst_hs();
        cpu_write(8'h10);
        check("R6 blind write ignored", {7'b0, cpu_rdata[4]}, 8'h00);
        cpu_read();
        cpu_write(8'h10);
        check("R6 read0 then write1", {7'b0, cpu_rdata[4]}, 8'h01);
        check("R6 sw_rst_o high", {7'b0, sw_rst_o}, 8'h01);
        cyc_match = 1; step(); cyc_match = 0;
        check("R3 sw reset blocks busy", {7'b0, cpu_rdata[7]}, 8'h00);
        cpu_write(8'h00);
        check("R6 write0 clears", {7'b0, cpu_rdata[4]}, 8'h00);
        check("R6 sw_rst_o low", {7'b0, sw_rst_o}, 8'h00);
        cpu_read();
        cpu_write(8'h00);
        cpu_write(8'h10);
        check("R6 consumed permission", {7'b0, cpu_rdata[4]}, 8'h00);
    endtask

    task automatic t_sdn_hs();
        cpu_write(8'h08);
        check("R7 blind write ignored", {7'b0, cpu_rdata[3]}, 8'h00);
        cpu_read();
        cpu_write(8'h08);
        check("R7 read0 then write1", {7'b0, cpu_rdata[3]}, 8'h01);
        frm_start = 1; step(); frm_start = 0;
        check("R4 shutdown blocks frame", {7'b0, cpu_rdata[5]}, 8'h00);
        cyc_match = 1; step(); cyc_match = 0;
        check("R3 shutdown blocks busy", {7'b0, cpu_rdata[7]}, 8'h00);
        lpc_hw_rst = 1; step(); lpc_hw_rst = 0;
        check("R7 hw reset clears", {7'b0, cpu_rdata[3]}, 8'h00);
        cpu_read();
        cpu_write(8'h08);
        cpu_read();
        cpu_write(8'h18);
        check("R7 held before sw reset acts", {6'b0, cpu_rdata[4:3]}, 8'h03);
        step();
        check("R7 sw reset clears", {7'b0, cpu_rdata[3]}, 8'h00);
        cpu_write(8'h00);
        check("R6 cleared after R7 test", {7'b0, cpu_rdata[4]}, 8'h00);
    endtask

    task automatic t_pd();
        pd_fall_sel = 0;
        pd_pin = 1; step(); step();
        check("R8 rise not yet", {7'b0, cpu_rdata[3]}, 8'h00);
        step();
        check("R8 rise enters shutdown", {7'b0, cpu_rdata[3]}, 8'h01);
        pd_pin = 0; step(); step(); step();
        check("R8 fall releases", {7'b0, cpu_rdata[3]}, 8'h00);
        pd_fall_sel = 1;
        pd_pin = 1; repeat (4) step();
        check("R8 rise is release in fall mode", {7'b0, cpu_rdata[3]}, 8'h00);
        pd_pin = 0; step(); step();
        check("R8 fall not yet", {7'b0, cpu_rdata[3]}, 8'h00);
        step();
        check("R8 fall enters shutdown", {7'b0, cpu_rdata[3]}, 8'h01);
        pd_pin = 1; repeat (3) step();
        check("R8 rise releases", {7'b0, cpu_rdata[3]}, 8'h00);
    endtask

    task automatic t_sb();
        sb_en = 3'b111;
        cpu_write(8'h00);
        check("R9 own enabled", {5'b0, sb_own_o}, 8'h07);
        check("R9 low all zero data", {5'b0, sb_low_o}, 8'h07);
        cpu_write(8'h05);
        check("R9 readback", {5'b0, cpu_rdata[2:0]}, 8'h05);
        check("R9 mixed data", {5'b0, sb_low_o}, 8'h02);
        sb_en = 3'b000; #1;
        check("R9 own disabled", {5'b0, sb_own_o}, 8'h00);
        check("R9 low disabled", {5'b0, sb_low_o}, 8'h00);
        sb_en = 3'b100; cpu_write(8'h00); #1;
        check("R9 partial enable", {5'b0, sb_low_o}, 8'h04);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        step();
        t_ro();
        t_busy();
        t_sirq();
        t_clk();
        t_rst_hs();
        t_sdn_hs();
        t_pd();
        t_sb();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule